// File: doc/BRIEF.md
# Banked GPIO Controller with Password-Guarded Protect Register

This block is a register-mapped general-purpose I/O controller. Its pins are grouped in banks of 32, and the number of banks is a parameter with a default of two. Software reaches it through a single-cycle 32-bit register port. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. Each pin has its own control word, which sets the pin direction, the edge that raises an interrupt, and a debounce length. Output levels change only through write-one-to-set and write-one-to-clear registers.

Every input pad passes through a two-flop synchroniser and then through a debounce filter. A qualifying edge on the filtered level sets a sticky per-pin status bit. Each bank drives one interrupt line, which is high when any unmasked status bit in that bank is set. Each bank also has a protect word. Software can rewrite it only after the password 0x00A5A501 has been written to the unlock register. The pad tristate buffers are outside this block. It only provides a level and an output enable per pin.

Top module: `gpio_bank_ctl`

## Requirements
- R1: `bus_addr` is a byte offset, and bits 1:0 are ignored. The map is as follows.
  - Bank registers sit at group base + 4*bank. The groups are output 0x000, input 0x020, set 0x040, clear 0x060, status 0x080, mask-set 0x0A0 and mask-clear 0x0C0.
  - The control word of pin p is at 0x100 + 4*p, where pin p is bit p%32 of bank p/32 (p >> 5).
  - The protect word of bank b is at 0x500 + 4*b. The unlock register is at 0x520.
  - Any offset outside these, including a bank index or pin index not below the configured count, reads zero. A write to it changes nothing.
- R2: Writing 1s to a bank's set register raises those bits of the output level `pad_out`. Writing 1s to its clear register lowers them. Zero bits leave the level unchanged. A write to the output register itself is ignored. The output, set and clear offsets all read back the current output level.
- R3: Control word bits 8:0 read back as written, and bits 31:9 read zero. Bit 0 = 1 makes the pin an input, and bit 0 = 0 makes it an output, so `pad_oe` for the pin is the inverse of bit 0. The control reset value is 0x001.
- R4: The input register returns the filtered pad level. With a debounce field of 0, a pad change made before clock edge k appears in the input register after edge k+2.
- R5: The debounce field is control bits 8:5, with value N. The filtered level takes a new pad value only after the synchronised pad has differed from it for 2^N consecutive clocks. A shorter excursion leaves the level unchanged.
- R6: Control bits 4:3 select the trigger: 0 none, 1 rising, 2 falling, 3 both. On an input pin, a selected change of the filtered level sets that pin's status bit on the edge where the level changes. Output pins never set status.
- R7: Writing 1s to the status register clears those bits. If a new event and a clearing write hit the same bit on the same edge, the bit stays set.
- R8: Writing 1s at the mask-set offset sets mask bits. Writing 1s at the mask-clear offset clears them, and both offsets read the mask. `bank_irq[b]` is high exactly when bank b has a status bit set whose mask bit is also set.
- R9: Writing exactly 0x00A5A501 to the unlock register arms the lock. The next write to any protect word then stores its data.
- R10: That protect write disarms the lock, whether or not it was stored. Without an armed lock, a protect write is ignored. Writing any other value to the unlock register does not arm it, and a write to any other register does not disarm it. The unlock register reads zero.
- R11: After reset, the output levels, status and mask are zero, every protect bit is one, every control word is 0x001, and the lock is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register at `bus_addr` |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 32*NUM_BANKS | Raw pad levels, pin p at bit p |
| pad_out | output | 32*NUM_BANKS | Output level per pin |
| pad_oe | output | 32*NUM_BANKS | Output enable per pin (1 = drive) |
| bank_irq | output | NUM_BANKS | Interrupt request per bank |

## Verification
The filter and interrupt path is driven three ways:
- A clean single step with no debounce fixes the two-clock synchroniser latency.
- A short glitch against a longer hold under a debounce of 3 shows that the 2^N count is exact, neither one clock early nor one clock late.
- A sparse random toggle pattern runs on all pins, with random control words, so that every trigger selection and direction combination is met.

Protect writes are tried without an unlock, after a wrong password, after an unrelated write between unlock and protect, and twice after a single unlock. These cases separate an arm that persists, an arm that is consumed, and an arm that was never set. A clearing write timed onto the same edge as a new event shows which of the two wins.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

  localparam int PINS_PER_BANK = 32;
  localparam int ADDR_W        = 12;
  localparam int CTRL_W        = 9;
  localparam int DBN_CNT_W     = 16;

  localparam logic [ADDR_W-1:0] CTRL_BASE   = 12'h100;
  localparam logic [ADDR_W-1:0] PROT_BASE   = 12'h500;
  localparam logic [ADDR_W-1:0] UNLOCK_ADDR = 12'h520;
  localparam logic [31:0]       UNLOCK_KEY  = 32'h00A5_A501;

  typedef enum logic [3:0] {
    K_NONE, K_OUT, K_IN, K_SET, K_CLR, K_ISTAT, K_IMASK, K_IMCLR,
    K_CTRL, K_PROT, K_UNLOCK
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [2:0]  bank;
    logic [7:0]  pin;
  } reg_sel_t;

  // Map a byte offset to a register kind plus bank / pin index.
  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a,
                                           input int nbanks);
    reg_sel_t s;
    logic [ADDR_W-1:0] rel;
    rel    = a - CTRL_BASE;
    s.kind = K_NONE;
    s.bank = a[4:2];
    s.pin  = rel[9:2];
    if (a[11:8] == 4'h0) begin
      if (int'(a[4:2]) < nbanks) begin
        case (a[7:5])
          3'd0:    s.kind = K_OUT;
          3'd1:    s.kind = K_IN;
          3'd2:    s.kind = K_SET;
          3'd3:    s.kind = K_CLR;
          3'd4:    s.kind = K_ISTAT;
          3'd5:    s.kind = K_IMASK;
          3'd6:    s.kind = K_IMCLR;
          default: s.kind = K_NONE;
        endcase
      end
    end else if (a >= CTRL_BASE && a < PROT_BASE) begin
      if (int'(s.pin) < nbanks * PINS_PER_BANK) s.kind = K_CTRL;
    end else if (a[11:5] == PROT_BASE[11:5]) begin
      if (int'(a[4:2]) < nbanks) s.kind = K_PROT;
    end else if (a[11:2] == UNLOCK_ADDR[11:2]) begin
      s.kind = K_UNLOCK;
    end
    return s;
  endfunction

  // Number of extra steady cycles before the filtered level may move.
  function automatic logic [DBN_CNT_W-1:0] dbn_limit(input logic [3:0] n);
    return (DBN_CNT_W'(1) << n) - DBN_CNT_W'(1);
  endfunction

  // Trigger select: bit 0 = rising, bit 1 = falling.
  function automatic logic edge_selected(input logic [1:0] trig,
                                         input logic rise, input logic fall);
    return (trig[0] & rise) | (trig[1] & fall);
  endfunction

endpackage

// File: rtl/gpio_pin_filter.sv
module gpio_pin_filter
  import gpio_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pad_i,
  input  logic [3:0] dbn_i,
  output logic       level_o,
  output logic       rise_o,
  output logic       fall_o
);

  logic                 sync1_q, sync2_q, level_q;
  logic [DBN_CNT_W-1:0] run_q;
  logic                 differs, take;

  assign differs = (sync2_q != level_q);
  assign take    = differs && (run_q >= dbn_limit(dbn_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      level_q <= 1'b0;
      run_q   <= '0;
    end else begin
      sync1_q <= pad_i;
      sync2_q <= sync1_q;
      if (take) begin
        level_q <= sync2_q;
        run_q   <= '0;
      end else if (differs) begin
        run_q   <= run_q + 1'b1;
      end else begin
        run_q   <= '0;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = take &  sync2_q;
  assign fall_o  = take & ~sync2_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_ctl_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PINS_PER_BANK-1:0] pad_i,
  input  logic [31:0]              wdata,
  input  logic                     we_set,
  input  logic                     we_clr,
  input  logic                     we_istat,
  input  logic                     we_imask,
  input  logic                     we_imclr,
  input  logic                     we_ctrl,
  input  logic [4:0]               ctrl_idx,
  input  logic                     we_prot,
  output logic [PINS_PER_BANK-1:0] out_o,
  output logic [PINS_PER_BANK-1:0] oe_o,
  output logic [PINS_PER_BANK-1:0] level_o,
  output logic [PINS_PER_BANK-1:0] istat_o,
  output logic [PINS_PER_BANK-1:0] imask_o,
  output logic [PINS_PER_BANK-1:0] prot_o,
  output logic [CTRL_W-1:0]        ctrl_rd_o,
  output logic [PINS_PER_BANK-1:0] evt_o,
  output logic                     irq_o
);

  logic [CTRL_W-1:0]        ctrl_q [PINS_PER_BANK];
  logic [PINS_PER_BANK-1:0] out_q, istat_q, imask_q, prot_q;
  logic [PINS_PER_BANK-1:0] rise, fall;

  for (genvar i = 0; i < PINS_PER_BANK; i++) begin : g_pin
    gpio_pin_filter u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pad_i   (pad_i[i]),
      .dbn_i   (ctrl_q[i][8:5]),
      .level_o (level_o[i]),
      .rise_o  (rise[i]),
      .fall_o  (fall[i])
    );
    assign evt_o[i] = ctrl_q[i][0] & edge_selected(ctrl_q[i][4:3], rise[i], fall[i]);
    assign oe_o[i]  = ~ctrl_q[i][0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PINS_PER_BANK; i++) ctrl_q[i] <= CTRL_W'(1);
    end else if (we_ctrl) begin
      ctrl_q[ctrl_idx] <= wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      istat_q <= '0;
      imask_q <= '0;
      prot_q  <= '1;
    end else begin
      if (we_set)   out_q   <= out_q | wdata;
      if (we_clr)   out_q   <= out_q & ~wdata;
      istat_q <= (istat_q & ~(we_istat ? wdata : '0)) | evt_o;
      if (we_imask) imask_q <= imask_q | wdata;
      if (we_imclr) imask_q <= imask_q & ~wdata;
      if (we_prot)  prot_q  <= wdata;
    end
  end

  assign out_o     = out_q;
  assign istat_o   = istat_q;
  assign imask_o   = imask_q;
  assign prot_o    = prot_q;
  assign ctrl_rd_o = ctrl_q[ctrl_idx];
  assign irq_o     = |(istat_q & imask_q);

endmodule

// File: rtl/gpio_bank_ctl.sv
module gpio_bank_ctl
  import gpio_ctl_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_we,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_in,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_out,
  output logic [NUM_BANKS*PINS_PER_BANK-1:0] pad_oe,
  output logic [NUM_BANKS-1:0]               bank_irq
);

  localparam int NPINS  = NUM_BANKS * PINS_PER_BANK;
  localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  reg_sel_t sel;
  assign sel = decode_addr(bus_addr, NUM_BANKS);

  // Named events for the checker
  logic unlock_ok, prot_wr, prot_commit, out_wr, armed_q;
  assign unlock_ok   = bus_we && sel.kind == K_UNLOCK && bus_wdata == UNLOCK_KEY;
  assign prot_wr     = bus_we && sel.kind == K_PROT;
  assign prot_commit = prot_wr && armed_q;
  assign out_wr      = bus_we && (sel.kind == K_SET || sel.kind == K_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (unlock_ok) armed_q <= 1'b1;
    else if (prot_wr)   armed_q <= 1'b0;
  end

  logic [31:0]       out_b   [NUM_BANKS];
  logic [31:0]       level_b [NUM_BANKS];
  logic [31:0]       istat_b [NUM_BANKS];
  logic [31:0]       imask_b [NUM_BANKS];
  logic [31:0]       prot_b  [NUM_BANKS];
  logic [CTRL_W-1:0] ctrl_b  [NUM_BANKS];
  logic [NPINS-1:0]  prot_flat, istat_flat, evt_flat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_we && (sel.bank == 3'(b));
    gpio_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .pad_i     (pad_in[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .wdata     (bus_wdata),
      .we_set    (hit && sel.kind == K_SET),
      .we_clr    (hit && sel.kind == K_CLR),
      .we_istat  (hit && sel.kind == K_ISTAT),
      .we_imask  (hit && sel.kind == K_IMASK),
      .we_imclr  (hit && sel.kind == K_IMCLR),
      .we_ctrl   (bus_we && sel.kind == K_CTRL && sel.pin[7:5] == 3'(b)),
      .ctrl_idx  (sel.pin[4:0]),
      .we_prot   (hit && prot_commit),
      .out_o     (out_b[b]),
      .oe_o      (pad_oe[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .level_o   (level_b[b]),
      .istat_o   (istat_b[b]),
      .imask_o   (imask_b[b]),
      .prot_o    (prot_b[b]),
      .ctrl_rd_o (ctrl_b[b]),
      .evt_o     (evt_flat[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .irq_o     (bank_irq[b])
    );
    assign pad_out[b*PINS_PER_BANK +: PINS_PER_BANK]    = out_b[b];
    assign prot_flat[b*PINS_PER_BANK +: PINS_PER_BANK]  = prot_b[b];
    assign istat_flat[b*PINS_PER_BANK +: PINS_PER_BANK] = istat_b[b];
  end

  logic [BIDX_W-1:0] rd_bank, rd_cbank;
  assign rd_bank  = sel.bank[BIDX_W-1:0];
  assign rd_cbank = sel.pin[5 +: BIDX_W];

  always_comb begin
    bus_rdata = '0;
    case (sel.kind)
      K_OUT, K_SET, K_CLR: bus_rdata = out_b[rd_bank];
      K_IN:                bus_rdata = level_b[rd_bank];
      K_ISTAT:             bus_rdata = istat_b[rd_bank];
      K_IMASK, K_IMCLR:    bus_rdata = imask_b[rd_bank];
      K_CTRL:              bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_b[rd_cbank]};
      K_PROT:              bus_rdata = prot_b[rd_bank];
      default:             bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bank_ctl_chk.sv
module gpio_bank_ctl_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    prot_commit,
  input logic                    out_wr,
  input logic                    armed_q,
  input logic [NUM_BANKS*32-1:0] prot_flat,
  input logic [NUM_BANKS*32-1:0] istat_flat,
  input logic [NUM_BANKS*32-1:0] evt_flat,
  input logic [NUM_BANKS*32-1:0] pad_out,
  input logic [NUM_BANKS-1:0]    bank_irq
);

  a_r10_prot_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !prot_commit |=> $stable(prot_flat));

  a_r10_unlock_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    prot_commit |=> !armed_q);

  a_r2_out_only_by_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !out_wr |=> $stable(pad_out));

  a_r6_status_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((istat_flat & ~$past(istat_flat) & ~$past(evt_flat)) == '0));

  a_r8_quiet_without_status: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_flat == '0) |-> (bank_irq == '0));

endmodule

bind gpio_bank_ctl gpio_bank_ctl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prot_commit (prot_commit),
  .out_wr      (out_wr),
  .armed_q     (armed_q),
  .prot_flat   (prot_flat),
  .istat_flat  (istat_flat),
  .evt_flat    (evt_flat),
  .pad_out     (pad_out),
  .bank_irq    (bank_irq)
);

// File: tb/sim_gpio_bank_ctl.sv
`timescale 1ns/1ps
module sim_gpio_bank_ctl;

  localparam int NB  = 2;
  localparam int NP  = NB * 32;
  localparam int KEY = 32'h00A5A501;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;
  logic [NB-1:0] bank_irq;

  always #10 clk = ~clk;

  gpio_bank_ctl #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .bank_irq(bank_irq)
  );

  int n_vec = 0, n_bad = 0;
  bit started = 0;

  // ---------------- behavioural reference ----------------
  bit [31:0] m_out[NB], m_stat[NB], m_mask[NB], m_prot[NB], m_ev[NB], m_w1c[NB];
  bit [8:0]  m_ctrl[NP];
  bit        m_s1[NP], m_s2[NP], m_lvl[NP];
  int        m_cnt[NP];
  bit        m_armed;

  // kinds: 0 none 1 out 2 in 3 set 4 clr 5 stat 6 mask 7 mclr 8 ctrl 9 prot 10 unlock
  function automatic int mdec(input int addr, output int b, output int p);
    int a;
    a = addr & 'hFFC;
    b = (a >> 2) & 7;
    p = (a - 'h100) >> 2;
    if (a < 'hE0) return (b < NB) ? (a >> 5) + 1 : 0;
    if (a >= 'h100 && a < 'h500) return (p < NP) ? 8 : 0;
    if (a >= 'h500 && a < 'h520) return (b < NB) ? 9 : 0;
    if (a == 'h520) return 10;
    return 0;
  endfunction

  function automatic bit [31:0] model_read(input int addr);
    int b, p, k;
    bit [31:0] v;
    k = mdec(addr, b, p);
    v = 0;
    case (k)
      1, 3, 4: v = m_out[b];
      2:       for (int i = 0; i < 32; i++) v[i] = m_lvl[b*32+i];
      5:       v = m_stat[b];
      6, 7:    v = m_mask[b];
      8:       v = {23'd0, m_ctrl[p]};
      9:       v = m_prot[b];
      default: v = 0;
    endcase
    return v;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_out[b] = 0; m_stat[b] = 0; m_mask[b] = 0; m_prot[b] = '1;
    end
    for (int p = 0; p < NP; p++) begin
      m_ctrl[p] = 9'h001; m_s1[p] = 0; m_s2[p] = 0; m_lvl[p] = 0; m_cnt[p] = 0;
    end
    m_armed = 0;
  endtask

  task automatic model_step();
    int b, p, k;
    for (int i = 0; i < NB; i++) begin m_ev[i] = 0; m_w1c[i] = 0; end
    for (int q = 0; q < NP; q++) begin
      if (m_s2[q] != m_lvl[q]) begin
        if (m_cnt[q] + 1 >= (1 << m_ctrl[q][8:5])) begin
          m_lvl[q] = m_s2[q];
          m_cnt[q] = 0;
          if (m_ctrl[q][0] && ((m_s2[q] && m_ctrl[q][3]) || (!m_s2[q] && m_ctrl[q][4])))
            m_ev[q/32][q%32] = 1;
        end else m_cnt[q]++;
      end else m_cnt[q] = 0;
      m_s2[q] = m_s1[q];
      m_s1[q] = pad_in[q];
    end
    if (bus_we) begin
      k = mdec(int'(bus_addr), b, p);
      case (k)
        3:  m_out[b]  = m_out[b] | bus_wdata;
        4:  m_out[b]  = m_out[b] & ~bus_wdata;
        5:  m_w1c[b]  = bus_wdata;
        6:  m_mask[b] = m_mask[b] | bus_wdata;
        7:  m_mask[b] = m_mask[b] & ~bus_wdata;
        8:  m_ctrl[p] = bus_wdata[8:0];
        9:  begin if (m_armed) m_prot[b] = bus_wdata; m_armed = 0; end
        10: if (bus_wdata == KEY) m_armed = 1;
        default: ;
      endcase
    end
    for (int i = 0; i < NB; i++) m_stat[i] = (m_stat[i] & ~m_w1c[i]) | m_ev[i];
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    started = 1;
  end

  // ---------------- checking ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  // per-clock comparison of registered outputs
  always @(negedge clk) begin
    if (started) begin
      logic [NP-1:0] e_out, e_oe;
      logic [NB-1:0] e_irq;
      for (int p = 0; p < NP; p++) begin
        e_out[p] = m_out[p/32][p%32];
        e_oe[p]  = ~m_ctrl[p][0];
      end
      for (int b = 0; b < NB; b++) e_irq[b] = |(m_stat[b] & m_mask[b]);
      chk("R2 pad_out", 64'(pad_out), 64'(e_out));
      chk("R3 pad_oe", 64'(pad_oe), 64'(e_oe));
      chk("R8 bank_irq", 64'(bank_irq), 64'(e_irq));
    end
  end

  task automatic rd_check(input int a, input string tag);
    bus_addr = 12'(a);
    #1;
    chk(tag, 64'(bus_rdata), 64'(model_read(a)));
  endtask

  task automatic rd_exp(input int a, input string tag, input logic [31:0] exp);
    bus_addr = 12'(a);
    #1;
    chk(tag, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1; bus_addr = 12'(a); bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(1);
    // R11 reset state
    rd_exp('h500, "R11 prot reset", 32'hFFFF_FFFF);
    rd_exp('h504, "R11 prot reset", 32'hFFFF_FFFF);
    rd_exp('h000, "R11 out reset", 32'h0);
    rd_exp('h0A4, "R11 mask reset", 32'h0);
    rd_exp('h17C, "R11 ctrl reset", 32'h1);
    chk("R11 oe reset", 64'(pad_oe), 64'h0);

    // R1 unmapped offsets
    rd_exp('h008, "R1 bank2 unmapped", 0);
    rd_exp('h0E0, "R1 hole", 0);
    rd_exp('h200, "R1 pin64 unmapped", 0);
    rd_exp('h508, "R1 prot bank2", 0);
    rd_exp('h520, "R1 unlock reads 0", 0);
    rd_exp('hFFC, "R1 top", 0);
    wr('h048, 32'hFFFF_FFFF);
    rd_exp('h000, "R1 write to unmapped", 0);

    // R2 set/clear
    wr('h040, 32'hF0F0_00F0);
    wr('h060, 32'h0000_0030);
    chk("R2 set/clr", 64'(pad_out[31:0]), 64'hF0F0_00C0);
    wr('h000, 32'h0);
    rd_exp('h040, "R2 set reads out", 32'hF0F0_00C0);
    rd_exp('h060, "R2 clr reads out", 32'hF0F0_00C0);
    wr('h044, 32'h1);
    chk("R2 bank1 set", 64'(pad_out[32]), 64'h1);

    // R3 direction
    wr('h110, 32'hFFFF_FE00);
    rd_exp('h110, "R3 ctrl readback", 32'h0);
    chk("R3 oe pin4", 64'(pad_oe[4]), 64'h1);

    // R4 latency + R6 rising
    wr('h104, 32'h009);
    pad_in[1] = 1;
    idle(2);
    rd_exp('h020, "R4 not yet", 32'h0);
    idle(1);
    rd_exp('h020, "R4 level after 3 edges", 32'h2);
    rd_exp('h080, "R6 rising sets status", 32'h2);
    wr('h080, 32'h2);
    pad_in[1] = 0;
    idle(4);
    rd_exp('h080, "R6 falling ignored on rising select", 32'h0);

    // R5 debounce on pin2 (falling, N=3)
    wr('h108, 32'h071);
    pad_in[2] = 1;
    idle(14);
    rd_exp('h020, "R5 high settled", 32'h4);
    rd_exp('h080, "R6 rise ignored on falling select", 32'h0);
    pad_in[2] = 0; idle(5); pad_in[2] = 1; idle(6);
    rd_exp('h020, "R5 glitch filtered", 32'h4);
    pad_in[2] = 0;
    idle(9);
    rd_exp('h020, "R5 one clock early", 32'h4);
    idle(1);
    rd_exp('h020, "R5 exact 2^N", 32'h0);
    rd_exp('h080, "R6 falling sets status", 32'h4);

    // R6 both edges on bank1 pin 33, output pin 34 ignored
    wr('h184, 32'h019);
    wr('h188, 32'h018);
    pad_in[33] = 1; pad_in[34] = 1; idle(3);
    pad_in[33] = 0; pad_in[34] = 0; idle(5);
    rd_exp('h084, "R6 both edges, output pin silent", 32'h2);

    // R7 clear vs simultaneous event
    wr('h080, 32'h4);
    rd_exp('h080, "R7 w1c", 32'h0);
    pad_in[1] = 1;
    idle(2);
    wr('h080, 32'h2);
    rd_exp('h080, "R7 event wins over clear", 32'h2);

    // R8 mask
    chk("R8 masked off", 64'(bank_irq), 64'h0);
    wr('h0A0, 32'h2);
    chk("R8 irq raised", 64'(bank_irq), 64'h1);
    wr('h0C0, 32'h2);
    chk("R8 irq dropped", 64'(bank_irq), 64'h0);
    wr('h0A0, 32'h10); wr('h0A0, 32'h1);
    rd_exp('h0A0, "R8 mask accumulates", 32'h11);
    rd_exp('h0C0, "R8 mask clear reads mask", 32'h11);

    // R9/R10 protect
    wr('h500, 32'h0);
    rd_exp('h500, "R10 no unlock ignored", 32'hFFFF_FFFF);
    wr('h520, 32'h00A5_A500);
    wr('h500, 32'h0);
    rd_exp('h500, "R10 wrong key ignored", 32'hFFFF_FFFF);
    wr('h520, KEY);
    wr('h040, 32'h0);
    wr('h504, 32'h0000_FFFF);
    rd_exp('h504, "R9 protect stored", 32'h0000_FFFF);
    wr('h504, 32'h0);
    rd_exp('h504, "R10 unlock consumed", 32'h0000_FFFF);
    wr('h520, KEY);
    wr('h500, 32'hFFFF_FFFE);
    rd_exp('h500, "R9 pin0 freed", 32'hFFFF_FFFE);

    // mixed random phase against the reference
    for (int c = 0; c < 600; c++) begin
      int sel, a;
      pad_in = pad_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      sel = $urandom % 10;
      a   = $urandom % NB;
      case (sel)
        0: wr('h100 + 4 * ($urandom % NP), ($urandom & 32'h09F));
        1: wr('h040 + 4 * a, $urandom);
        2: wr('h060 + 4 * a, $urandom);
        3: wr('h080 + 4 * a, $urandom);
        4: wr('h0A0 + 4 * a, $urandom);
        5: wr('h0C0 + 4 * a, $urandom);
        6: wr('h520, ($urandom % 2) ? KEY : $urandom);
        7: wr('h500 + 4 * a, $urandom);
        default: idle(1);
      endcase
      rd_check($urandom % 'h600, "R1 random read");
    end
    idle(2);
    finish_run();
  end

endmodule